// File: doc/BRIEF.md
# Single-Bus Multicycle Processor Datapath

This block is a small processor core in which every register and the one ALU exchange data over a single shared internal bus. It holds a program counter, four general-purpose registers, a memory-address register, a memory-data register, an instruction register and two ALU operand latches. A hardwired step counter raises the bus-drive and register-load strobes for each step. At most one source drives the bus in any step, so every operand of an add is staged into its own latch in its own cycle.

All arithmetic goes through the ALU, and that includes the program-counter increment. A memory read always takes two steps. The first loads the address register, and the next captures the returned word. An instruction spends two steps in fetch and then runs its execute steps. The core shows the shared bus value, the current step and a one-cycle completion pulse, so the sequence can be followed from outside.

Top module: `sbus_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter, all registers and the step counter. The cycle after reset shows step 0, `mem_addr` 0 and `done_o` low.
- R2: At most one source drives the shared bus in any step. `bus_o` shows that source's value, or zero when no source drives the bus.
- R3: Fetch step 0 places the PC on the bus and loads it into the address register. In the same step the ALU writes PC+1 back into the PC.
- R4: Fetch step 1 leaves the bus idle (0). The word at `mem_addr` is loaded into both the memory-data register and the instruction register.
- R5: The instruction word has its opcode in bits [W-1:W-4], the destination index in bits [3:2] and the source index in bits [1:0]. Opcode 1 is ADD. Its execute phase drives the destination register onto the bus in step 2, then the source register in step 3, then their sum in step 4.
- R6: The ADD result is the sum modulo 2^W. It is written into the destination register, and this also holds when the destination and source are the same register.
- R7: Opcode 2 is LOAD. In step 2 the PC goes onto the bus, is loaded into the address register and is incremented through the ALU. In step 3 the memory word is captured and the bus is idle. In step 4 that word goes onto the bus and is written into the destination register.
- R8: Any other opcode pulses `done_o` in step 2, changes no register and returns to fetch.
- R9: `done_o` is high for exactly one cycle per instruction, and the next cycle is step 0.
- R10: `step_o` counts 0, 1, 2, 3, 4 for ADD and LOAD, and never exceeds 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | W | Memory read address (address register) |
| mem_rdata | input | W | Memory word for the address held on `mem_addr` |
| bus_o | output | W | Current value of the shared internal bus |
| step_o | output | 3 | Current control step (0..4) |
| done_o | output | 1 | One-cycle pulse in an instruction's last step |

## Verification
The assertions check a set of properties on every cycle:
- At most one bus-drive enable is active.
- Fetch step 0 puts the PC on the bus, and the PC has grown by one in the following cycle.
- The address register takes the bus value.
- Fetch step 1 leaves the bus idle.
- `done_o` appears only in step 2 or step 4, lasts a single cycle and leads back to step 0.

Only the bench scenarios can show the rest. These are the operand order on the bus, the wrap of the sum, a register added to itself, the immediate word reaching its destination, and unknown opcodes leaving every register unchanged. The bench observes these through later adds that read the registers back onto the bus.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

  typedef enum logic [2:0] {
    ST_F0 = 3'd0,
    ST_F1 = 3'd1,
    ST_E0 = 3'd2,
    ST_E1 = 3'd3,
    ST_E2 = 3'd4
  } step_e;

  typedef struct packed {
    logic oe_pc;
    logic oe_gpr;
    logic oe_alu;
    logic oe_mdr;
    logic ld_mar;
    logic ld_pc;
    logic ld_mdr;
    logic ld_ir;
    logic ld_s;
    logic ld_t;
    logic ld_gpr;
    logic alu_inc;
    logic rd_src;
    logic done;
  } ctrl_t;

endpackage

// File: rtl/sbus_alu.sv
module sbus_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  function automatic logic [W-1:0] add_w(input logic [W-1:0] x, input logic [W-1:0] z);
    return W'(x + z);
  endfunction

  assign y = add_w(a, b);

endmodule

// File: rtl/sbus_gpr.sv
module sbus_gpr #(
  parameter int W    = 16,
  parameter int NREG = 4,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ridx,
  output logic [W-1:0]  rdata
);

  logic [NREG-1:0][W-1:0] rf;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                           q <= '0;
      else if (we && widx == IW'(i))     q <= wdata;
    end
    assign rf[i] = q;
  end

  assign rdata = rf[ridx];

endmodule

// File: rtl/sbus_ctrl.sv
module sbus_ctrl
  import sbus_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  is_add,
  input  logic  is_load,
  output step_e step_q,
  output ctrl_t c
);

  always_comb begin
    c = '0;
    unique case (step_q)
      ST_F0: begin
        c.oe_pc = 1'b1; c.ld_mar = 1'b1; c.ld_pc = 1'b1; c.alu_inc = 1'b1;
      end
      ST_F1: begin
        c.ld_mdr = 1'b1; c.ld_ir = 1'b1;
      end
      ST_E0: begin
        if (is_add) begin
          c.oe_gpr = 1'b1; c.ld_s = 1'b1;
        end else if (is_load) begin
          c.oe_pc = 1'b1; c.ld_mar = 1'b1; c.ld_pc = 1'b1; c.alu_inc = 1'b1;
        end else begin
          c.done = 1'b1;
        end
      end
      ST_E1: begin
        if (is_add) begin
          c.oe_gpr = 1'b1; c.rd_src = 1'b1; c.ld_t = 1'b1;
        end else if (is_load) begin
          c.ld_mdr = 1'b1;
        end
      end
      ST_E2: begin
        if (is_add) c.oe_alu = 1'b1;
        else        c.oe_mdr = 1'b1;
        c.ld_gpr = 1'b1;
        c.done   = 1'b1;
      end
      default: c = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         step_q <= ST_F0;
    else if (c.done) step_q <= ST_F0;
    else             step_q <= step_e'(3'(step_q + 3'd1));
  end

endmodule

// File: rtl/sbus_core.sv
module sbus_core
  import sbus_pkg::*;
#(
  parameter int W       = 16,
  parameter int NREG    = 4,
  parameter int OPW     = 4,
  parameter int OP_ADD  = 1,
  parameter int OP_LOAD = 2
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] mem_addr,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] bus_o,
  output logic [2:0]   step_o,
  output logic         done_o
);

  localparam int IW = $clog2(NREG);

  ctrl_t        c;
  step_e        step_q;
  logic [W-1:0] pc_q, mar_q, mdr_q, ir_q, s_q, t_q;
  logic [W-1:0] gpr_rd, alu_y, alu_a, alu_b, bus_nalu, bus;
  logic [IW-1:0] f_dst, f_src;
  logic [OPW-1:0] f_op;
  logic [3:0]   oe_vec;

  assign f_op  = ir_q[W-1:W-OPW];
  assign f_dst = ir_q[2*IW-1:IW];
  assign f_src = ir_q[IW-1:0];

  sbus_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .is_add  (f_op == OPW'(OP_ADD)),
    .is_load (f_op == OPW'(OP_LOAD)),
    .step_q  (step_q),
    .c       (c)
  );

  sbus_gpr #(.W(W), .NREG(NREG)) u_gpr (
    .clk   (clk),
    .rst   (rst),
    .we    (c.ld_gpr),
    .widx  (f_dst),
    .wdata (bus),
    .ridx  (c.rd_src ? f_src : f_dst),
    .rdata (gpr_rd)
  );

  // AND-OR bus: non-ALU sources first, ALU result merged last
  assign bus_nalu = ({W{c.oe_pc}}  & pc_q)
                  | ({W{c.oe_gpr}} & gpr_rd)
                  | ({W{c.oe_mdr}} & mdr_q);
  assign alu_a    = c.alu_inc ? bus_nalu : s_q;
  assign alu_b    = c.alu_inc ? W'(1)    : t_q;
  assign bus      = c.oe_alu ? alu_y : bus_nalu;
  assign oe_vec   = {c.oe_pc, c.oe_gpr, c.oe_alu, c.oe_mdr};

  sbus_alu #(.W(W)) u_alu (
    .a (alu_a),
    .b (alu_b),
    .y (alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
      s_q   <= '0;
      t_q   <= '0;
    end else begin
      if (c.ld_pc)  pc_q  <= alu_y;
      if (c.ld_mar) mar_q <= bus;
      if (c.ld_mdr) mdr_q <= mem_rdata;
      if (c.ld_ir)  ir_q  <= mem_rdata;
      if (c.ld_s)   s_q   <= bus;
      if (c.ld_t)   t_q   <= bus;
    end
  end

  assign mem_addr = mar_q;
  assign bus_o    = bus;
  assign step_o   = step_q;
  assign done_o   = c.done;

endmodule

// File: rtl/sbus_core_chk.sv
module sbus_core_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [3:0]   oe_vec,
  input logic [2:0]   step,
  input logic         done,
  input logic [W-1:0] pc_q,
  input logic [W-1:0] mar_q,
  input logic [W-1:0] bus
);

  p_one_driver_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(oe_vec));

  p_fetch_bus_r3: assert property (@(posedge clk) disable iff (rst)
    (step == 3'd0) |-> (bus == pc_q));

  p_pc_inc_r3: assert property (@(posedge clk) disable iff (rst)
    (step == 3'd0) |=> (pc_q == W'($past(pc_q) + 1'b1)));

  p_mar_load_r3: assert property (@(posedge clk) disable iff (rst)
    (step == 3'd0) |=> (mar_q == $past(bus)));

  p_f1_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (step == 3'd1) |-> (bus == '0));

  p_done_place_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (step == 3'd2 || step == 3'd4));

  p_done_return_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> (step == 3'd0));

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_step_legal_r10: assert property (@(posedge clk) disable iff (rst)
    step <= 3'd4);

endmodule

bind sbus_core sbus_core_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .oe_vec (oe_vec),
  .step   (step_o),
  .done   (done_o),
  .pc_q   (pc_q),
  .mar_q  (mar_q),
  .bus    (bus_o)
);

// File: tb/sbus_core_tb.sv
module sbus_core_tb;

  localparam int W    = 16;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] mem_addr, mem_rdata, bus_o;
  logic [2:0]   step_o;
  logic         done_o;
  logic [W-1:0] mem [64];
  bit           finished = 1'b0;

  always #4 clk = ~clk;

  assign mem_rdata = mem[mem_addr[5:0]];

  sbus_core u_dut (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .bus_o     (bus_o),
    .step_o    (step_o),
    .done_o    (done_o)
  );

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  int m_step = 0, m_pc = 0, m_mar = 0, m_mdr = 0, m_ir = 0, m_s = 0, m_t = 0;
  int m_r[4] = '{0, 0, 0, 0};
  bit was_reset = 1'b1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int e_bus, e_done, op, d, s;
    string tag;
    op = (m_ir >> 12) & 15;
    d  = (m_ir >> 2) & 3;
    s  = m_ir & 3;
    e_bus  = 0;
    e_done = 0;
    case (m_step)
      0: begin tag = "R3"; e_bus = m_pc; end
      1: tag = "R4";
      2: begin
        if (op == 1)      begin tag = "R5"; e_bus = m_r[d]; end
        else if (op == 2) begin tag = "R7"; e_bus = m_pc; end
        else              begin tag = "R8"; e_done = 1; end
      end
      3: begin
        if (op == 1) begin tag = "R5"; e_bus = m_r[s]; end
        else         tag = "R7";
      end
      default: begin
        e_done = 1;
        if (op == 1) begin tag = "R6"; e_bus = (m_s + m_t) & MASK; end
        else         begin tag = "R7"; e_bus = m_mdr; end
      end
    endcase
    if (was_reset) tag = "R1";
    chk({tag, " R10 step"}, int'(step_o), m_step);
    chk({tag, " mem_addr"}, int'(mem_addr), m_mar);
    chk({tag, " R2 bus"}, int'(bus_o), e_bus);
    chk({tag, " R9 done"}, int'(done_o), e_done);

    // advance the model to the state after the coming edge
    case (m_step)
      0: begin m_mar = m_pc; m_pc = (m_pc + 1) & MASK; m_step = 1; end
      1: begin m_mdr = int'(mem[m_mar[5:0]]); m_ir = m_mdr; m_step = 2; end
      2: begin
        if (op == 1)      begin m_s = m_r[d]; m_step = 3; end
        else if (op == 2) begin m_mar = m_pc; m_pc = (m_pc + 1) & MASK; m_step = 3; end
        else              m_step = 0;
      end
      3: begin
        if (op == 1) m_t = m_r[s];
        else         m_mdr = int'(mem[m_mar[5:0]]);
        m_step = 4;
      end
      default: begin m_r[d] = e_bus; m_step = 0; end
    endcase
    if (rst) begin
      m_step = 0; m_pc = 0; m_mar = 0; m_mdr = 0; m_ir = 0; m_s = 0; m_t = 0;
      for (int i = 0; i < 4; i++) m_r[i] = 0;
    end
    was_reset = rst;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem[0]  = 16'h2004;  // LOAD R1 (R7)
    mem[1]  = 16'h0005;
    mem[2]  = 16'h2000;  // LOAD R0
    mem[3]  = 16'hFFFE;
    mem[4]  = 16'h1001;  // ADD R0,R1 wraps to 3 (R6)
    mem[5]  = 16'h1005;  // ADD R1,R1 self add (R6)
    mem[6]  = 16'hF000;  // unknown opcode (R8)
    mem[7]  = 16'h1008;  // ADD R2,R0
    mem[8]  = 16'h200C;  // LOAD R3
    mem[9]  = 16'h1234;
    mem[10] = 16'h100F;  // ADD R3,R3
    mem[11] = 16'h1006;  // ADD R1,R2 reads back R1 and R2 (R5)
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    repeat (70) @(posedge clk);
    #1 rst = 1'b1;               // mid-run reset (R1)
    @(posedge clk);
    #1 rst = 1'b0;
    repeat (50) @(posedge clk);
    @(negedge clk);
    #1;
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R9 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule